// File: doc/BRIEF.md
# Product-Term Logic Cell with Term Expanders

This block is a single logic cell of a sum-of-products programmable array. A bank of 36 global routing lines feeds five local AND terms. Each term may take any line in true form, any line in complemented form, and any of 15 shared expander inputs. A routing mask chooses which local terms reach the cell's OR gate. A second mask can hand terms over to the neighbouring cell instead, through a parallel expander chain. An incoming parallel expander from the other neighbour can be ORed into the cell's own sum, passed further along the chain, or both.

After the OR gate, the sum goes through a polarity stage. A flip-flop can then be bypassed, giving either a combinational or a registered result. The result drives a pad whose driver can be turned off. When the pad is configured as an input, its level is sent back to the array through the feedback output. The fifth term is also exported in inverted form so that peer cells can use it as a shared expander. All configuration arrives on static input ports. The reset `rst_n` is asynchronous and active low, and is expected to have a synchronous release upstream.

Top module: `pterm_macrocell`

## Requirements
- R1: Term t (t = 0..4) is the AND of every literal selected for it. Bit t*36+i of `cfg_lit_true` selects line i in true form, and the same bit of `cfg_lit_comp` selects it in complemented form. A term with nothing selected evaluates to 1. Selecting both forms of one line forces the term to 0.
- R2: Bit t*15+j of `cfg_shx_sel` ANDs shared expander input `shx_in[j]` into term t.
- R3: `shx_out` always equals the inverse of term 4.
- R4: Term t reaches the OR gate only when `cfg_term_en[t]` is 1 and `cfg_lend[t]` is 0.
- R5: When `cfg_par_use` is 1, `par_in` is ORed into the cell's sum. When it is 0, `par_in` has no effect on the sum.
- R6: A term with `cfg_lend[t]` set drives `par_out` and is removed from the cell's own sum. When `cfg_par_fwd` is 1, `par_in` is also ORed into `par_out`.
- R7: With `cfg_invert` at 1 the sum is inverted. With it at 0 the sum passes through unchanged.
- R8: With `cfg_registered` at 0, `pin_out` follows the polarity result in the same cycle.
- R9: With `cfg_registered` at 1, `pin_out` shows the flip-flop. The flip-flop loads the polarity result on a rising clock edge when `ff_ena` is 1, and holds its value when `ff_ena` is 0.
- R10: `ff_srst` clears the flip-flop at the next rising edge and takes priority over `ff_ena`. `rst_n` low clears it at once.
- R11: With `cfg_pin_input` at 1, `pin_oe` is 0 and `fb_out` equals `pin_in`. With it at 0, `pin_oe` is 1 and `fb_out` equals `pin_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ic_lines | input | 36 | Global routing lines |
| shx_in | input | 15 | Shared expander terms from peer cells |
| par_in | input | 1 | Parallel expander from neighbour |
| cfg_lit_true | input | 180 | True-literal selection, 36 bits per term |
| cfg_lit_comp | input | 180 | Complement-literal selection, 36 bits per term |
| cfg_shx_sel | input | 75 | Shared expander selection, 15 bits per term |
| cfg_term_en | input | 5 | Routing mask into own OR gate |
| cfg_lend | input | 5 | Terms lent to the parallel chain |
| cfg_par_use | input | 1 | OR `par_in` into own sum |
| cfg_par_fwd | input | 1 | Pass `par_in` on to `par_out` |
| cfg_invert | input | 1 | Output polarity inversion |
| cfg_registered | input | 1 | Select registered result |
| cfg_pin_input | input | 1 | Use the pad as an input |
| ff_ena | input | 1 | Flip-flop clock enable |
| ff_srst | input | 1 | Flip-flop synchronous clear |
| pin_in | input | 1 | Level sensed at the pad |
| pin_out | output | 1 | Pad output value |
| pin_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback to the array |
| shx_out | output | 1 | Inverted term 4 as shared expander |
| par_out | output | 1 | Lent terms to the neighbour |

## Verification
The AND plane is driven with all four combinations of a mixed true/complement two-literal term. This separates a dropped inversion from a dropped literal. Empty and contradictory terms check the identity values of the AND gate. Shared expander and routing mask cases flip one input at a time, so that an unwanted or ignored dependence appears as a changed output. The lend and forward cases watch `par_out` and `pin_out` together, which separates a term that is lent from one that is duplicated. The register is walked through load, hold, clear-over-enable and reload to tell enable priority apart from clear priority.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  localparam int unsigned MC_LINES  = 36;
  localparam int unsigned MC_TERMS  = 5;
  localparam int unsigned MC_SHARED = 15;

  // A literal passes unless its selected form disagrees with the line level
  function automatic logic literal_ok(input logic v, input logic use_t, input logic use_c);
    return (~use_t | v) & (~use_c | ~v);
  endfunction
endpackage

// File: rtl/mc_and_plane.sv
`timescale 1ns/1ps
module mc_and_plane
  import mc_pkg::*;
#(
  parameter int unsigned N_LINES  = MC_LINES,
  parameter int unsigned N_TERMS  = MC_TERMS,
  parameter int unsigned N_SHARED = MC_SHARED
) (
  input  logic [N_LINES-1:0]          ic_lines,
  input  logic [N_SHARED-1:0]         shx_in,
  input  logic [N_TERMS*N_LINES-1:0]  cfg_lit_true,
  input  logic [N_TERMS*N_LINES-1:0]  cfg_lit_comp,
  input  logic [N_TERMS*N_SHARED-1:0] cfg_shx_sel,
  output logic [N_TERMS-1:0]          terms_o
);
  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic prod;
    always_comb begin
      prod = 1'b1;
      for (int i = 0; i < N_LINES; i++) begin
        prod = prod & literal_ok(ic_lines[i], cfg_lit_true[t*N_LINES+i],
                                 cfg_lit_comp[t*N_LINES+i]);
      end
      for (int j = 0; j < N_SHARED; j++) begin
        prod = prod & (~cfg_shx_sel[t*N_SHARED+j] | shx_in[j]);
      end
    end
    assign terms_o[t] = prod;
  end
endmodule

// File: rtl/mc_sum.sv
`timescale 1ns/1ps
module mc_sum #(
  parameter int unsigned N_TERMS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_TERMS-1:0] terms_i,
  input  logic [N_TERMS-1:0] cfg_term_en,
  input  logic [N_TERMS-1:0] cfg_lend,
  input  logic               cfg_par_use,
  input  logic               cfg_par_fwd,
  input  logic               par_in,
  output logic               sum_o,
  output logic               par_out
);
  logic [N_TERMS-1:0] own_terms;
  logic [N_TERMS-1:0] lent_terms;

  assign own_terms  = terms_i & cfg_term_en & ~cfg_lend;
  assign lent_terms = terms_i & cfg_lend;
  assign sum_o      = (|own_terms) | (par_in & cfg_par_use);
  assign par_out    = (|lent_terms) | (par_in & cfg_par_fwd);

  // R6: with every term lent and no borrowing, nothing can raise the own sum
  a_r6_lent_removed: assert property (@(posedge clk) disable iff (!rst_n)
    (&cfg_lend && !cfg_par_use) |-> !sum_o);
  // R5: a borrowed active expander always reaches the sum
  a_r5_borrow_reaches: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_par_use && par_in) |-> sum_o);
  // R6: forwarding passes the incoming chain on
  a_r6_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_par_fwd && par_in) |-> par_out);
endmodule

// File: rtl/mc_output.sv
`timescale 1ns/1ps
module mc_output (
  input  logic clk,
  input  logic rst_n,
  input  logic sum_i,
  input  logic cfg_invert,
  input  logic cfg_registered,
  input  logic cfg_pin_input,
  input  logic ff_ena,
  input  logic ff_srst,
  input  logic pin_in,
  output logic pin_out,
  output logic pin_oe,
  output logic fb_out
);
  logic pol;
  logic q_r;
  logic q_d;

  assign pol = sum_i ^ cfg_invert;

  always_comb begin
    q_d = q_r;
    if (ff_srst)     q_d = 1'b0;
    else if (ff_ena) q_d = pol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign pin_out = cfg_registered ? q_r : pol;
  assign pin_oe  = ~cfg_pin_input;
  assign fb_out  = cfg_pin_input ? pin_in : pin_out;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ff_ena && !ff_srst) |=> (q_r == $past(q_r)));
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ff_ena && !ff_srst) |=> (q_r == $past(sum_i ^ cfg_invert)));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ff_srst |=> !q_r);
endmodule

// File: rtl/pterm_macrocell.sv
`timescale 1ns/1ps
module pterm_macrocell
  import mc_pkg::*;
#(
  parameter int unsigned N_LINES  = MC_LINES,
  parameter int unsigned N_TERMS  = MC_TERMS,
  parameter int unsigned N_SHARED = MC_SHARED,
  localparam int unsigned LIT_W   = N_TERMS * N_LINES,
  localparam int unsigned SHX_W   = N_TERMS * N_SHARED
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LINES-1:0]  ic_lines,
  input  logic [N_SHARED-1:0] shx_in,
  input  logic                par_in,
  input  logic [LIT_W-1:0]    cfg_lit_true,
  input  logic [LIT_W-1:0]    cfg_lit_comp,
  input  logic [SHX_W-1:0]    cfg_shx_sel,
  input  logic [N_TERMS-1:0]  cfg_term_en,
  input  logic [N_TERMS-1:0]  cfg_lend,
  input  logic                cfg_par_use,
  input  logic                cfg_par_fwd,
  input  logic                cfg_invert,
  input  logic                cfg_registered,
  input  logic                cfg_pin_input,
  input  logic                ff_ena,
  input  logic                ff_srst,
  input  logic                pin_in,
  output logic                pin_out,
  output logic                pin_oe,
  output logic                fb_out,
  output logic                shx_out,
  output logic                par_out
);
  logic [N_TERMS-1:0] terms;
  logic               sum;

  mc_and_plane #(.N_LINES(N_LINES), .N_TERMS(N_TERMS), .N_SHARED(N_SHARED)) u_plane (
    .ic_lines    (ic_lines),
    .shx_in      (shx_in),
    .cfg_lit_true(cfg_lit_true),
    .cfg_lit_comp(cfg_lit_comp),
    .cfg_shx_sel (cfg_shx_sel),
    .terms_o     (terms)
  );

  // The last term doubles as the exported shared expander (R3)
  assign shx_out = ~terms[N_TERMS-1];

  mc_sum #(.N_TERMS(N_TERMS)) u_sum (
    .clk        (clk),
    .rst_n      (rst_n),
    .terms_i    (terms),
    .cfg_term_en(cfg_term_en),
    .cfg_lend   (cfg_lend),
    .cfg_par_use(cfg_par_use),
    .cfg_par_fwd(cfg_par_fwd),
    .par_in     (par_in),
    .sum_o      (sum),
    .par_out    (par_out)
  );

  mc_output u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .sum_i         (sum),
    .cfg_invert    (cfg_invert),
    .cfg_registered(cfg_registered),
    .cfg_pin_input (cfg_pin_input),
    .ff_ena        (ff_ena),
    .ff_srst       (ff_srst),
    .pin_in        (pin_in),
    .pin_out       (pin_out),
    .pin_oe        (pin_oe),
    .fb_out        (fb_out)
  );

  // R11: an input-configured pad never drives
  a_r11_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pin_input |-> !pin_oe);
endmodule

// File: tb/pterm_macrocell_tb.sv
`timescale 1ns/1ps
module pterm_macrocell_tb;
  localparam int NL = 36;
  localparam int NT = 5;
  localparam int NS = 15;

  logic clk = 1'b0;
  logic rst_n;
  logic [NL-1:0] ic_lines;
  logic [NS-1:0] shx_in;
  logic par_in;
  logic [NT*NL-1:0] cfg_lit_true, cfg_lit_comp;
  logic [NT*NS-1:0] cfg_shx_sel;
  logic [NT-1:0] cfg_term_en, cfg_lend;
  logic cfg_par_use, cfg_par_fwd, cfg_invert, cfg_registered, cfg_pin_input;
  logic ff_ena, ff_srst, pin_in;
  logic pin_out, pin_oe, fb_out, shx_out, par_out;

  always #2.5 clk = ~clk;

  pterm_macrocell u_dut (
    .clk(clk), .rst_n(rst_n), .ic_lines(ic_lines), .shx_in(shx_in), .par_in(par_in),
    .cfg_lit_true(cfg_lit_true), .cfg_lit_comp(cfg_lit_comp), .cfg_shx_sel(cfg_shx_sel),
    .cfg_term_en(cfg_term_en), .cfg_lend(cfg_lend), .cfg_par_use(cfg_par_use),
    .cfg_par_fwd(cfg_par_fwd), .cfg_invert(cfg_invert), .cfg_registered(cfg_registered),
    .cfg_pin_input(cfg_pin_input), .ff_ena(ff_ena), .ff_srst(ff_srst), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out), .shx_out(shx_out), .par_out(par_out)
  );

  typedef struct {
    logic  pout;
    logic  oe;
    logic  fb;
    logic  shx;
    logic  par;
    string req;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int   vectors = 0;
  int   miscompares = 0;
  bit   finished = 0;
  logic model_q;

  function automatic logic [NT-1:0] m_terms();
    logic [NT-1:0] r;
    for (int t = 0; t < NT; t++) begin
      logic p;
      p = 1'b1;
      for (int i = 0; i < NL; i++) begin
        if (cfg_lit_true[t*NL+i] && !ic_lines[i]) p = 1'b0;
        if (cfg_lit_comp[t*NL+i] &&  ic_lines[i]) p = 1'b0;
      end
      for (int j = 0; j < NS; j++)
        if (cfg_shx_sel[t*NS+j] && !shx_in[j]) p = 1'b0;
      r[t] = p;
    end
    return r;
  endfunction

  function automatic logic m_pol();
    logic [NT-1:0] tm;
    tm = m_terms();
    return ((|(tm & cfg_term_en & ~cfg_lend)) | (par_in & cfg_par_use)) ^ cfg_invert;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       model_q = 1'b0;
    else if (ff_srst) model_q = 1'b0;
    else if (ff_ena)  model_q = m_pol();
  end

  // Driver: computes the expected item and hands it to the monitor
  task automatic step(input string req);
    exp_t e;
    logic [NT-1:0] tm;
    #1;
    tm     = m_terms();
    e.pout = cfg_registered ? model_q : m_pol();
    e.oe   = !cfg_pin_input;
    e.fb   = cfg_pin_input ? pin_in : e.pout;
    e.shx  = ~tm[NT-1];
    e.par  = (|(tm & cfg_lend)) | (par_in & cfg_par_fwd);
    e.req  = req;
    exp_q.push_back(e);
    ->chk_ev;
    @(negedge clk);
  endtask

  // Monitor
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        vectors++;
        if ({pin_out, pin_oe, fb_out, shx_out, par_out} !== {e.pout, e.oe, e.fb, e.shx, e.par}) begin
          miscompares++;
          $display("FAIL %s: got out=%b oe=%b fb=%b shx=%b par=%b expected out=%b oe=%b fb=%b shx=%b par=%b",
                   e.req, pin_out, pin_oe, fb_out, shx_out, par_out,
                   e.pout, e.oe, e.fb, e.shx, e.par);
        end
      end
    end
  end

  task automatic clear_cfg();
    ic_lines = '0; shx_in = '0; par_in = 0;
    cfg_lit_true = '0; cfg_lit_comp = '0; cfg_shx_sel = '0;
    cfg_term_en = '0; cfg_lend = '0;
    cfg_par_use = 0; cfg_par_fwd = 0; cfg_invert = 0;
    cfg_registered = 0; cfg_pin_input = 0;
    ff_ena = 0; ff_srst = 0; pin_in = 0;
  endtask

  task automatic lit(input int t, input int i, input bit tr, input bit cp);
    cfg_lit_true[t*NL+i] = tr;
    cfg_lit_comp[t*NL+i] = cp;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    clear_cfg();
    @(negedge clk);
    // R10: asynchronous reset holds the register at 0
    cfg_registered = 1; ff_ena = 1; cfg_term_en = 5'b00001;
    step("R10 reset");
    rst_n = 1; ff_ena = 0; cfg_registered = 0;
    clear_cfg();

    // R1: term0 = line0 & ~line1
    lit(0, 0, 1, 0); lit(0, 1, 0, 1); cfg_term_en = 5'b00001;
    for (int k = 0; k < 4; k++) begin
      ic_lines[1:0] = k[1:0];
      step("R1 mixed literals");
    end
    // R1: empty term is 1, contradictory term is 0
    clear_cfg(); cfg_term_en = 5'b00100;
    step("R1 empty term");
    lit(2, 7, 1, 1); ic_lines[7] = 1;
    step("R1 contradictory term");

    // R2: term1 = line2 & shx_in[3]
    clear_cfg(); lit(1, 2, 1, 0); cfg_shx_sel[1*NS+3] = 1; cfg_term_en = 5'b00010;
    for (int k = 0; k < 4; k++) begin
      ic_lines[2] = k[0]; shx_in[3] = k[1];
      step("R2 shared expander");
    end

    // R3: term4 = line5 exported inverted
    clear_cfg(); lit(4, 5, 1, 0);
    ic_lines[5] = 0; step("R3 export low");
    ic_lines[5] = 1; step("R3 export high");

    // R4: only the enabled term counts
    clear_cfg(); lit(0, 0, 1, 0); lit(3, 3, 1, 0); cfg_term_en = 5'b01000;
    ic_lines[0] = 1; step("R4 masked term ignored");
    ic_lines[3] = 1; step("R4 enabled term passes");

    // R5: borrowing
    clear_cfg(); par_in = 1;
    step("R5 par_in unused");
    cfg_par_use = 1; step("R5 par_in used");

    // R6: lending and forwarding
    clear_cfg(); lit(0, 0, 1, 0); cfg_term_en = 5'b00001; cfg_lend = 5'b00001;
    ic_lines[0] = 1; step("R6 lent term leaves own sum");
    ic_lines[0] = 0; par_in = 1; step("R6 no forward");
    cfg_par_fwd = 1; step("R6 forward");

    // R7 / R8: polarity and combinational path
    clear_cfg(); cfg_term_en = 5'b00100; cfg_invert = 1;
    step("R7 invert true sum");
    cfg_term_en = 5'b00000; step("R7 invert false sum");
    cfg_invert = 0; lit(0, 9, 1, 0); cfg_term_en = 5'b00001;
    ic_lines[9] = 1; step("R8 comb follows");
    ic_lines[9] = 0; step("R8 comb follows low");

    // R9: register load and hold
    clear_cfg(); cfg_registered = 1; lit(0, 0, 1, 0); cfg_term_en = 5'b00001;
    ic_lines[0] = 1; ff_ena = 1;
    step("R9 before load");
    step("R9 loaded");
    ff_ena = 0; ic_lines[0] = 0;
    step("R9 hold");
    step("R9 hold again");
    ff_ena = 1; step("R9 reload");
    ic_lines[0] = 1; step("R9 load again");

    // R10: synchronous clear wins over enable
    ff_srst = 1; step("R10 clear pending");
    step("R10 cleared");
    ff_srst = 0; step("R10 release");

    // R11: pad as input
    clear_cfg(); cfg_pin_input = 1; cfg_term_en = 5'b00100;
    pin_in = 0; step("R11 input low");
    pin_in = 1; step("R11 input high");
    cfg_pin_input = 0; step("R11 output mode");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule